// File: doc/BRIEF.md
# PCM Codec Serial Port

This block is the digital serial port of an 8-bit PCM codec. In each frame it sends one sample out on a transmit data line and takes one sample in from a receive data line. All framing comes from three inputs: an external bit clock, a transmit frame-sync and a receive frame-sync. The block samples these inputs with a fast system clock and turns each bit-clock transition into a one-cycle strobe. It does not assume a fixed ratio between the bit clock and the system clock, and it does not assume a fixed number of bit clocks per frame.

The port works out the sync style from the width of the sync pulse. It counts the falling bit-clock edges seen while sync is high. One or two such edges mean a short sync. Three or more mean a long sync. A frame is always launched with the short-sync rule until a long pulse has been measured. The measured style is recorded when sync falls, and it sets the launch rule for the next frame in that direction. It also sets the release rule of the current frame. While the transmit output is enabled, an active-low slot indicator is driven. Outside the slot the output is reported as undriven through an output-enable.

Top module: `pcm_serial_port`

## Requirements
- R1: During and right after reset, `dx_oe` is 0, `tsx_n` is 1 and `rx_valid` is 0.
- R2: For each direction, a sync pulse that spans at most two falling bit-clock edges is classed short, and one that spans three or more is classed long. The class is recorded when sync falls, and it sets the launch rule of the next frame in that direction. After reset the recorded class is short.
- R3: With a short recorded class, the frame's sync rising edge is qualified by the next falling bit-clock edge. The first transmit bit is then driven from the rising bit-clock edge that follows, and `dx_oe` goes high there.
- R4: With a long recorded class, the first transmit bit is driven from the later of the sync rising edge and a rising bit-clock edge. If the bit clock is already high when sync rises, `dx_oe` goes high at the sync edge.
- R5: `tx_byte` is captured on the transmit sync rising edge. It is sent MSB first on `dx`, and each following bit appears after a rising bit-clock edge.
- R6: `dx_oe` drops on the falling bit-clock edge that ends the eighth bit. If the current pulse is long and sync is still high at that edge, `dx_oe` instead drops when sync falls.
- R7: `tsx_n` is 0 exactly while `dx_oe` is 1. It asserts on the same edge that launches the first bit.
- R8: `dr` is sampled on falling bit-clock edges, MSB first. The receive side uses the same first-bit rule as R3 and R4, applied to its own sync and its own recorded class. After the eighth sample, `rx_byte` holds the sample and `rx_valid` is high for exactly one cycle.
- R9: A sync rising edge that arrives before the current frame has finished aborts that frame. The output is released at once, the partial receive byte is dropped without `rx_valid`, and framing restarts from the new edge.
- R10: Behaviour does not depend on the bit-clock period measured in system clocks, as long as each bit-clock phase lasts at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, synchronous to `clk` |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| dr | input | 1 | Receive serial data |
| tx_byte | input | 8 | Sample to send, captured on transmit sync rise |
| dx | output | 1 | Transmit serial data (meaningful while `dx_oe` is 1) |
| dx_oe | output | 1 | Transmit output enable (0 = high impedance) |
| tsx_n | output | 1 | Active-low transmit slot indicator |
| rx_byte | output | 8 | Last complete received sample |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
Some rules are checked on every cycle by properties. The output enable may rise only after a bit-clock rise or a sync rise. It may fall only after a bit-clock fall or a sync edge. Transmit data stays still between launch edges. The receive strobe lasts a single cycle and follows a falling bit-clock edge. The recorded sync class changes only when sync falls. Other behaviour can only be shown by the bench's frames: the exact bit position of the first bit under each recorded class, the hold of the output past the eighth bit for a long pulse, the bit values sent and received, the effect of an aborted frame, and operation at several bit-clock rates.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_WAIT_FALL,
        TX_WAIT_RISE,
        TX_SHIFT,
        TX_HOLD
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SYNC,
        RX_RECV
    } rx_st_e;

    // Per-input edge strobes produced from the oversampled inputs
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Transmit state entered on a sync rising edge
    function automatic tx_st_e tx_launch_state(input logic prev_long, input logic bclk_hi);
        if (!prev_long)
            return TX_WAIT_FALL;
        else if (bclk_hi)
            return TX_SHIFT;
        else
            return TX_WAIT_RISE;
    endfunction

    // Receive state entered on a sync rising edge
    function automatic rx_st_e rx_launch_state(input logic prev_long);
        return prev_long ? RX_RECV : RX_SYNC;
    endfunction

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
    parameter int N = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            sig,
    output pcm_pkg::edge_t [N-1:0]  ev
);
    logic [N-1:0] sig_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sig_q[i] <= 1'b0;
            else
                sig_q[i] <= sig[i];
        end
        assign ev[i].rise = sig[i] & ~sig_q[i];
        assign ev[i].fall = ~sig[i] & sig_q[i];
    end
endmodule

// File: rtl/pcm_fs_mode.sv
module pcm_fs_mode #(
    parameter int LONG_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_lvl,
    input  logic fs_rise,
    input  logic fs_fall,
    input  logic bclk_fall,
    output logic prev_long,
    output logic cur_long
);
    localparam int CW = $clog2(LONG_MIN + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            prev_long <= 1'b0;
        end else begin
            if (fs_rise)
                hi_cnt <= '0;
            else if (fs_lvl && bclk_fall && hi_cnt < CW'(LONG_MIN))
                hi_cnt <= hi_cnt + 1'b1;
            if (fs_fall)
                prev_long <= cur_long;
        end
    end

    assign cur_long = (hi_cnt == CW'(LONG_MIN));

    // R2: recorded class only moves when sync falls
    a_r2_class_on_sync_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(prev_long) |-> $past(fs_fall));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bclk_lvl,
    input  logic         bclk_rise,
    input  logic         bclk_fall,
    input  logic         fs_lvl,
    input  logic         fs_rise,
    input  logic         fs_fall,
    input  logic         prev_long,
    input  logic         cur_long,
    input  logic [W-1:0] tx_byte,
    output logic         dx,
    output logic         dx_oe
);
    import pcm_pkg::*;

    localparam int BW = $clog2(W);

    tx_st_e        st;
    logic [W-1:0]  sr;
    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TX_IDLE;
            sr  <= '0;
            cnt <= '0;
        end else if (fs_rise) begin
            sr  <= tx_byte;
            cnt <= '0;
            st  <= tx_launch_state(prev_long, bclk_lvl);
        end else begin
            case (st)
                TX_WAIT_FALL: if (bclk_fall) st <= TX_WAIT_RISE;
                TX_WAIT_RISE: if (bclk_rise) st <= TX_SHIFT;
                TX_SHIFT: begin
                    if (bclk_rise) begin
                        sr  <= {sr[W-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                    end else if (bclk_fall && cnt == BW'(W - 1)) begin
                        st <= (fs_lvl && cur_long) ? TX_HOLD : TX_IDLE;
                    end
                end
                TX_HOLD: if (fs_fall) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign dx_oe = (st == TX_SHIFT) || (st == TX_HOLD);
    assign dx    = sr[W-1];

    // R3/R4: the output is enabled only by a bit-clock rise or a sync rise
    a_r4_enable_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(dx_oe) |-> $past(bclk_rise || fs_rise));

    // R6/R9: the output is released only by a bit-clock fall or a sync edge
    a_r6_release_on_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(dx_oe) |-> $past(bclk_fall || fs_fall || fs_rise));

    // R5: data holds still between launch edges
    a_r5_dx_stable: assert property (@(posedge clk) disable iff (rst)
        (dx_oe && $past(dx_oe) && !$past(bclk_rise) && !$past(fs_rise)) |-> $stable(dx));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bclk_fall,
    input  logic         fs_rise,
    input  logic         prev_long,
    input  logic         dr,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    import pcm_pkg::*;

    localparam int BW = $clog2(W);

    rx_st_e        st;
    logic [W-1:0]  sr;
    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            sr       <= '0;
            cnt      <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (fs_rise) begin
                cnt <= '0;
                st  <= rx_launch_state(prev_long);
            end else begin
                case (st)
                    RX_SYNC: if (bclk_fall) st <= RX_RECV;
                    RX_RECV: begin
                        if (bclk_fall) begin
                            sr  <= {sr[W-2:0], dr};
                            cnt <= cnt + 1'b1;
                            if (cnt == BW'(W - 1)) begin
                                rx_byte  <= {sr[W-2:0], dr};
                                rx_valid <= 1'b1;
                                st       <= RX_IDLE;
                            end
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R8: a single-cycle strobe
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: the strobe follows a falling bit-clock edge
    a_r8_valid_after_fall: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bclk_fall));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int WORD_W   = 8,
    parameter int LONG_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              fsx,
    input  logic              fsr,
    input  logic              dr,
    input  logic [WORD_W-1:0] tx_byte,
    output logic              dx,
    output logic              dx_oe,
    output logic              tsx_n,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);
    import pcm_pkg::*;

    localparam int I_BCLK = 0;
    localparam int I_FSX  = 1;
    localparam int I_FSR  = 2;
    localparam int N_IN   = 3;

    edge_t [N_IN-1:0] ev;
    logic tx_prev_long, tx_cur_long;
    logic rx_prev_long, rx_cur_long;

    pcm_edge_det #(.N(N_IN)) u_edges (
        .clk (clk),
        .rst (rst),
        .sig ({fsr, fsx, bclk}),
        .ev  (ev)
    );

    pcm_fs_mode #(.LONG_MIN(LONG_MIN)) u_tx_mode (
        .clk       (clk),
        .rst       (rst),
        .fs_lvl    (fsx),
        .fs_rise   (ev[I_FSX].rise),
        .fs_fall   (ev[I_FSX].fall),
        .bclk_fall (ev[I_BCLK].fall),
        .prev_long (tx_prev_long),
        .cur_long  (tx_cur_long)
    );

    pcm_fs_mode #(.LONG_MIN(LONG_MIN)) u_rx_mode (
        .clk       (clk),
        .rst       (rst),
        .fs_lvl    (fsr),
        .fs_rise   (ev[I_FSR].rise),
        .fs_fall   (ev[I_FSR].fall),
        .bclk_fall (ev[I_BCLK].fall),
        .prev_long (rx_prev_long),
        .cur_long  (rx_cur_long)
    );

    pcm_tx_slot #(.W(WORD_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .bclk_lvl  (bclk),
        .bclk_rise (ev[I_BCLK].rise),
        .bclk_fall (ev[I_BCLK].fall),
        .fs_lvl    (fsx),
        .fs_rise   (ev[I_FSX].rise),
        .fs_fall   (ev[I_FSX].fall),
        .prev_long (tx_prev_long),
        .cur_long  (tx_cur_long),
        .tx_byte   (tx_byte),
        .dx        (dx),
        .dx_oe     (dx_oe)
    );

    pcm_rx_slot #(.W(WORD_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bclk_fall (ev[I_BCLK].fall),
        .fs_rise   (ev[I_FSR].rise),
        .prev_long (rx_prev_long),
        .dr        (dr),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    assign tsx_n = ~dx_oe;

    // R2: the receive-side long flag never reads long while its sync is low and unmeasured
    a_r2_rx_long_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_cur_long) |-> $past(fsr && ev[I_BCLK].fall));
endmodule

// File: tb/tb_pcm_serial_port.sv
`timescale 1ns/1ps
module tb_pcm_serial_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       fsx = 1'b0;
    logic       fsr = 1'b0;
    logic       dr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       dx, dx_oe, tsx_n, rx_valid;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_bad = 0;
    int H = 3;
    bit prev_long_exp = 1'b0;
    int rx_seen = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcm_serial_port dut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsx(fsx), .fsr(fsr), .dr(dr),
        .tx_byte(tx_byte), .dx(dx), .dx_oe(dx_oe), .tsx_n(tsx_n),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid) begin
            rx_seen <= rx_seen + 1;
            rx_last <= rx_byte;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_oe(input int p, input bit high_ph, input int fp, input int lp, input int d);
        if (p < fp) return 1'b0;
        if (high_ph) return (p <= lp) || (p < d);
        return (p < lp) || (p < d);
    endfunction

    task automatic check_phase(input int p, input bit high_ph, input int fp, input int lp,
                               input int d, input logic [7:0] txb, input bit plong);
        bit eo;
        int k;
        string tag;
        eo = exp_oe(p, high_ph, fp, lp, d);
        if (p == fp)      tag = plong ? "R2 R4 launch" : "R2 R3 launch";
        else if (p >= lp) tag = "R6 release";
        else              tag = "R5 shift";
        chk(dx_oe == eo, tag, dx_oe, eo);
        chk(tsx_n == !eo, "R7 slot indicator", tsx_n, !eo);
        if (eo) begin
            k = p - fp;
            if (k > 7) k = 7;
            chk(dx == txb[7-k], "R5 data bit", dx, txb[7-k]);
        end
    endtask

    task automatic run_frame(input int w, input bit in_high, input logic [7:0] txb,
                             input logic [7:0] rxb, input int abort_at);
        int fp, lp, d, n, rx0;
        bit plong;
        plong = prev_long_exp;
        fp = plong ? (in_high ? 0 : 1) : (in_high ? 1 : 2);
        lp = fp + 7;
        d  = in_high ? w : w + 1;
        n  = ((lp > d) ? lp : d) + 2;
        if (abort_at >= 0) n = fp + abort_at;
        rx0 = rx_seen;
        tx_byte = txb;
        @(negedge clk);
        for (int p = 0; p < n; p++) begin
            bclk = 1'b1;
            if (p >= fp && p <= lp) dr = rxb[7-(p-fp)];
            @(negedge clk);
            if (p == 0 && in_high) begin fsx = 1'b1; fsr = 1'b1; end
            if (p == d)            begin fsx = 1'b0; fsr = 1'b0; end
            repeat (H - 1) @(negedge clk);
            check_phase(p, 1'b1, fp, lp, d, txb, plong);
            bclk = 1'b0;
            @(negedge clk);
            if (p == 0 && !in_high) begin fsx = 1'b1; fsr = 1'b1; end
            repeat (H - 1) @(negedge clk);
            check_phase(p, 1'b0, fp, lp, d, txb, plong);
        end
        if (abort_at >= 0) begin
            chk(rx_seen == rx0, "R9 aborted frame gives no strobe", rx_seen - rx0, 0);
        end else begin
            chk(rx_seen == rx0 + 1, "R8 one strobe per frame", rx_seen - rx0, 1);
            chk(rx_last == rxb, "R8 R10 received byte", rx_last, rxb);
        end
        prev_long_exp = (w >= 3);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(dx_oe == 1'b0, "R1 oe in reset", dx_oe, 0);
        chk(tsx_n == 1'b1, "R1 slot in reset", tsx_n, 1);
        chk(rx_valid == 1'b0, "R1 strobe in reset", rx_valid, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(dx_oe == 1'b0, "R1 oe after reset", dx_oe, 0);
        chk(tsx_n == 1'b1, "R1 slot after reset", tsx_n, 1);

        // Directed frames
        H = 3;
        run_frame(1, 1'b1, 8'hA5, 8'h3C, -1);   // short, R3
        run_frame(2, 1'b1, 8'h81, 8'hE7, -1);   // short, two periods
        run_frame(4, 1'b1, 8'h5A, 8'h0F, -1);   // long pulse, still short-launched (R2)
        run_frame(8, 1'b1, 8'hC3, 8'h96, -1);   // long launch at sync edge, hold past 8th bit (R4, R6)
        run_frame(5, 1'b0, 8'h7E, 8'h41, -1);   // long launch at next bclk rise (R4)
        run_frame(1, 1'b1, 8'h18, 8'hFF, -1);   // short pulse launched long-style, records short (R2)
        H = 2;
        run_frame(1, 1'b1, 8'hF0, 8'h55, 4);    // aborted mid-frame (R9)
        run_frame(2, 1'b1, 8'h0F, 8'hAA, -1);   // clean frame after the abort (R9)

        // Random frames at several bit-clock rates (R10)
        for (int i = 0; i < 40; i++) begin
            int w;
            bit hi;
            case ($urandom_range(3, 0))
                0: H = 2;
                1: H = 3;
                2: H = 5;
                default: H = 8;
            endcase
            w  = $urandom_range(8, 1);
            hi = (w <= 2) ? 1'b1 : 1'($urandom_range(1, 0));
            run_frame(w, hi, 8'($urandom), 8'($urandom), -1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule